// File: doc/BRIEF.md
# Power-Up Strap and CPU Frequency-Select Latch

This block captures a set of board configuration straps at the moment the power-good input first rises after reset, then holds them for the rest of the session. The straps are the three-bit CPU frequency-select code, a trusted-mode strap that forbids overclocking, a strap that turns the two stop-control pins into an extra differential clock pair, and a strap that assigns the third CPU output pair to debug use. The latched values drive an overclock-lock flag, the pin-function selects for the shared pins, and a decoded CPU frequency. The frequency is given in units of 10 kHz, so 26666 stands for 266.66 MHz.

After the straps are latched, a management mode lets a controller replace the frequency-select code. In that mode the code is shifted in serially, most significant bit first, on a data line that has its own shift clock. Both serial inputs are sampled by the block clock. The new code takes effect on the third rising shift clock. A reserved code is never applied. Instead it raises an error flag.

A controller FSM has four states: SAMPLE (the shared pins still act as strap inputs), RUN (normal operation), PWRDN (power-good has dropped after the straps were latched) and MGMT (serial loading is allowed). Its transitions are:
- SAMPLE→RUN on the first rising power-good. This is the only latch.
- RUN→PWRDN when power-good is low.
- PWRDN→RUN when power-good is high again.
- RUN→MGMT when management mode is requested.
- MGMT→RUN when that request drops.

Top module: `strap_latch`

## Requirements
- R1: After reset the outputs are as follows: strap_phase=1, straps_valid=0, powered_down=0, in_mgmt=0, fs_code=3'b101, cpu_freq=10000, fs_err=0, oc_lock=0, stop_pins_pair=0, cpu2_debug=0.
- R2: On the first clock edge that samples pwr_good high after reset, the block latches all straps. Also on that edge straps_valid rises and strap_phase falls. While pwr_good stays low nothing is latched.
- R3: cpu_freq decodes fs_code as {C,B,A}, in 10 kHz units: 000→26666, 001→13333, 010→20000, 011→16666, 100→33333, 101→10000, 110→40000.
- R4: Once latched, the latched straps do not change when strap inputs change or pwr_good toggles. fs_code changes only through a serial load (R7).
- R5: When pwr_good is low while the FSM is in RUN, powered_down=1 from the next edge on. powered_down clears on the edge after pwr_good is high again.
- R6: When mgmt_mode is high in RUN, in_mgmt=1 from the next edge on. When mgmt_mode is low, in_mgmt clears the same way. Before the straps are latched, mgmt_mode has no effect.
- R7: In MGMT, each rising ser_clk shifts in ser_data, MSB (C) first. On the third rise the code {b1,b2,b3} is applied to fs_code on that same edge. The shift count then restarts.
- R8: If MGMT is left after fewer than three rises, fs_code is unchanged and the partial bits are discarded. The next load starts from its first bit.
- R9: A latched or shifted code of 3'b111 is reserved. It sets fs_err=1 and leaves fs_code at its previous value. Any later valid code that is applied clears fs_err.
- R10: Outside MGMT, ser_clk and ser_data have no effect on fs_code.
- R11: oc_lock equals the latched trust_strap (1 forbids overclocking). stop_pins_pair equals the latched pair5_strap (1 means the stop pins carry the extra clock pair, 0 means stop controls). cpu2_debug equals the latched dbg_strap (1 means debug pair, 0 means ordinary pair).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pwr_good | input | 1 | Power-good / power-down input |
| mgmt_mode | input | 1 | Requests management mode |
| fs_strap | input | 3 | Raw frequency-select straps {C,B,A} |
| trust_strap | input | 1 | Raw trusted-mode strap |
| pair5_strap | input | 1 | Raw strap choosing the stop-pin function |
| dbg_strap | input | 1 | Raw strap choosing the CPU2 pair function |
| ser_clk | input | 1 | Serial shift clock, sampled by clk |
| ser_data | input | 1 | Serial frequency-select data |
| strap_phase | output | 1 | Shared pins are still strap inputs |
| straps_valid | output | 1 | Straps have been latched |
| powered_down | output | 1 | FSM is in PWRDN |
| in_mgmt | output | 1 | FSM is in MGMT |
| fs_code | output | 3 | Active frequency-select code |
| cpu_freq | output | 16 | Decoded CPU frequency, 10 kHz units |
| fs_err | output | 1 | Last offered code was reserved |
| oc_lock | output | 1 | Overclocking forbidden |
| stop_pins_pair | output | 1 | Stop pins serve as a clock pair |
| cpu2_debug | output | 1 | CPU2 pair serves debug |

## Verification
The third rising shift clock of a serial load can be sampled on the same edge that sees mgmt_mode fall. Because the FSM is still in MGMT on that edge, the load commits while in_mgmt drops. The bench shifts two bits, then drives the third ser_clk rise and the fall of mgmt_mode together. One sample later it expects both the new fs_code and in_mgmt=0. A design that gates the commit on the raw mode input loses the code and is reported.

// File: rtl/strap_latch_pkg.sv
package strap_latch_pkg;

    typedef enum logic [1:0] {
        ST_SAMPLE = 2'd0,
        ST_RUN    = 2'd1,
        ST_PWRDN  = 2'd2,
        ST_MGMT   = 2'd3
    } strap_state_e;

    localparam int FS_W   = 3;
    localparam int FREQ_W = 16;
    localparam logic [FS_W-1:0] FS_RESERVED = '1;

    // CPU frequency in 10 kHz units for each select code
    function automatic logic [FREQ_W-1:0] fs_to_freq(input logic [FS_W-1:0] code);
        logic [FREQ_W-1:0] f;
        unique case (code)
            3'b000:  f = 16'd26666;
            3'b001:  f = 16'd13333;
            3'b010:  f = 16'd20000;
            3'b011:  f = 16'd16666;
            3'b100:  f = 16'd33333;
            3'b101:  f = 16'd10000;
            3'b110:  f = 16'd40000;
            default: f = 16'd0;
        endcase
        return f;
    endfunction

endpackage

// File: rtl/strap_ctrl_fsm.sv
module strap_ctrl_fsm
    import strap_latch_pkg::*;
(
    input  logic         clk,
    input  logic         rst_n,
    input  logic         pwr_good,
    input  logic         mgmt_mode,
    output strap_state_e state,
    output logic         latch_pulse
);

    strap_state_e state_nx;
    logic         pg_prev;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state   <= ST_SAMPLE;
            pg_prev <= 1'b0;
        end else begin
            state   <= state_nx;
            pg_prev <= pwr_good;
        end
    end

    always_comb begin
        state_nx    = state;
        latch_pulse = 1'b0;
        unique case (state)
            ST_SAMPLE: begin
                if (pwr_good && !pg_prev) begin
                    state_nx    = ST_RUN;
                    latch_pulse = 1'b1;
                end
            end
            ST_RUN: begin
                if (!pwr_good)      state_nx = ST_PWRDN;
                else if (mgmt_mode) state_nx = ST_MGMT;
            end
            ST_PWRDN: begin
                if (pwr_good) state_nx = ST_RUN;
            end
            ST_MGMT: begin
                if (!mgmt_mode) state_nx = ST_RUN;
            end
        endcase
    end

    AST_NO_MGMT_BEFORE_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SAMPLE) |=> (state != ST_MGMT)); // R6

    AST_PWRDN_ONLY_FROM_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SAMPLE) |=> (state != ST_PWRDN)); // R5

endmodule

// File: rtl/fs_serial_loader.sv
module fs_serial_loader #(
    parameter int CODE_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic              ser_clk,
    input  logic              ser_data,
    output logic              load_valid,
    output logic [CODE_W-1:0] load_code
);

    localparam int CNT_W = (CODE_W > 2) ? $clog2(CODE_W) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(CODE_W - 1);

    logic              sclk_prev;
    logic              sclk_rise;
    logic [CNT_W-1:0]  cnt;
    logic [CODE_W-2:0] sh;

    assign sclk_rise  = ser_clk && !sclk_prev;
    assign load_valid = enable && sclk_rise && (cnt == LAST);
    assign load_code  = {sh, ser_data};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sclk_prev <= 1'b0;
            cnt       <= '0;
            sh        <= '0;
        end else begin
            sclk_prev <= ser_clk;
            if (!enable) begin
                cnt <= '0;
            end else if (sclk_rise) begin
                if (cnt == LAST) begin
                    cnt <= '0;
                end else begin
                    cnt <= cnt + 1'b1;
                    if (CODE_W > 2) sh <= {sh[CODE_W-3:0], ser_data};
                    else            sh <= ser_data;
                end
            end
        end
    end

    AST_SHIFT_COUNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= LAST); // R7

    AST_COUNT_CLEARED_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (cnt == '0)); // R8

endmodule

// File: rtl/freq_decoder.sv
module freq_decoder
    import strap_latch_pkg::*;
(
    input  logic [FS_W-1:0]   code,
    output logic [FREQ_W-1:0] freq
);
    always_comb freq = fs_to_freq(code);
endmodule

// File: rtl/strap_latch.sv
module strap_latch
    import strap_latch_pkg::*;
#(
    parameter logic [2:0] DEFAULT_FS = 3'b101
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        pwr_good,
    input  logic        mgmt_mode,
    input  logic [2:0]  fs_strap,
    input  logic        trust_strap,
    input  logic        pair5_strap,
    input  logic        dbg_strap,
    input  logic        ser_clk,
    input  logic        ser_data,
    output logic        strap_phase,
    output logic        straps_valid,
    output logic        powered_down,
    output logic        in_mgmt,
    output logic [2:0]  fs_code,
    output logic [15:0] cpu_freq,
    output logic        fs_err,
    output logic        oc_lock,
    output logic        stop_pins_pair,
    output logic        cpu2_debug
);

    strap_state_e     state;
    logic             latch_pulse;
    logic             load_valid;
    logic [FS_W-1:0]  load_code;
    logic             offer;
    logic [FS_W-1:0]  offer_code;
    logic             valid_q, trust_q, pair_q, dbg_q, err_q;
    logic [FS_W-1:0]  fs_q;

    strap_ctrl_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .pwr_good    (pwr_good),
        .mgmt_mode   (mgmt_mode),
        .state       (state),
        .latch_pulse (latch_pulse)
    );

    fs_serial_loader #(.CODE_W(FS_W)) u_loader (
        .clk        (clk),
        .rst_n      (rst_n),
        .enable     (state == ST_MGMT),
        .ser_clk    (ser_clk),
        .ser_data   (ser_data),
        .load_valid (load_valid),
        .load_code  (load_code)
    );

    freq_decoder u_dec (
        .code (fs_q),
        .freq (cpu_freq)
    );

    assign offer      = latch_pulse || load_valid;
    assign offer_code = latch_pulse ? fs_strap : load_code;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            valid_q <= 1'b0;
            trust_q <= 1'b0;
            pair_q  <= 1'b0;
            dbg_q   <= 1'b0;
            fs_q    <= DEFAULT_FS;
            err_q   <= 1'b0;
        end else begin
            if (latch_pulse) begin
                valid_q <= 1'b1;
                trust_q <= trust_strap;
                pair_q  <= pair5_strap;
                dbg_q   <= dbg_strap;
            end
            if (offer) begin
                if (offer_code == FS_RESERVED) begin
                    err_q <= 1'b1;
                end else begin
                    err_q <= 1'b0;
                    fs_q  <= offer_code;
                end
            end
        end
    end

    always_comb begin
        strap_phase    = (state == ST_SAMPLE);
        powered_down   = (state == ST_PWRDN);
        in_mgmt        = (state == ST_MGMT);
        straps_valid   = valid_q;
        fs_code        = fs_q;
        fs_err         = err_q;
        oc_lock        = trust_q;
        stop_pins_pair = pair_q;
        cpu2_debug     = dbg_q;
    end

    AST_VALID_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        straps_valid |=> straps_valid); // R4

    AST_STRAPS_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        straps_valid |=> $stable({oc_lock, stop_pins_pair, cpu2_debug})); // R4

    AST_NO_RESERVED_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        fs_code != FS_RESERVED); // R9

    AST_FS_FROZEN_OUTSIDE_MGMT: assert property (@(posedge clk) disable iff (!rst_n)
        (straps_valid && !in_mgmt) |=> $stable(fs_code)); // R10

    AST_PHASE_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        strap_phase |-> !straps_valid); // R2

endmodule

// File: tb/strap_latch_bench.sv
`timescale 1ns/1ps
module strap_latch_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pwr_good = 1'b0, mgmt_mode = 1'b0;
    logic [2:0]  fs_strap = 3'b000;
    logic        trust_strap = 1'b0, pair5_strap = 1'b0, dbg_strap = 1'b0;
    logic        ser_clk = 1'b0, ser_data = 1'b0;
    logic        strap_phase, straps_valid, powered_down, in_mgmt;
    logic [2:0]  fs_code;
    logic [15:0] cpu_freq;
    logic        fs_err, oc_lock, stop_pins_pair, cpu2_debug;

    int vectors = 0;
    int miscompares = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    strap_latch u_strap_latch (
        .clk(clk), .rst_n(rst_n), .pwr_good(pwr_good), .mgmt_mode(mgmt_mode),
        .fs_strap(fs_strap), .trust_strap(trust_strap), .pair5_strap(pair5_strap),
        .dbg_strap(dbg_strap), .ser_clk(ser_clk), .ser_data(ser_data),
        .strap_phase(strap_phase), .straps_valid(straps_valid),
        .powered_down(powered_down), .in_mgmt(in_mgmt), .fs_code(fs_code),
        .cpu_freq(cpu_freq), .fs_err(fs_err), .oc_lock(oc_lock),
        .stop_pins_pair(stop_pins_pair), .cpu2_debug(cpu2_debug)
    );

    function automatic int exp_freq(input int code);
        int mhz100;
        case (code)
            0: mhz100 = 26666;  1: mhz100 = 13333;  2: mhz100 = 20000;
            3: mhz100 = 16666;  4: mhz100 = 33333;  5: mhz100 = 10000;
            6: mhz100 = 40000;  default: mhz100 = 0;
        endcase
        return mhz100;
    endfunction

    task automatic chk(input string tag, input int act, input int exp);
        vectors++;
        if (act != exp) begin
            miscompares++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_reset();
        rst_n = 1'b0; pwr_good = 1'b0; mgmt_mode = 1'b0;
        ser_clk = 1'b0; ser_data = 1'b0;
        step(2);
        rst_n = 1'b1;
        step(1);
    endtask

    task automatic shift_bit(input logic b);
        ser_data = b; ser_clk = 1'b1;
        step(1);
        ser_clk = 1'b0;
        step(1);
    endtask

    task automatic shift_code(input int code);
        for (int i = 2; i >= 0; i--) shift_bit(code[i]);
    endtask

    task automatic finish_run();
        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    endtask

    initial begin
        #(200000 * 4);
        if (!finished) begin
            miscompares++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            finish_run();
        end
    end

    initial begin
        int model_fs;
        int model_err;

        // R1 reset state
        do_reset();
        chk("R1 strap_phase", strap_phase, 1);
        chk("R1 straps_valid", straps_valid, 0);
        chk("R1 powered_down", powered_down, 0);
        chk("R1 in_mgmt", in_mgmt, 0);
        chk("R1 fs_code", fs_code, 5);
        chk("R1 cpu_freq", cpu_freq, 10000);
        chk("R1 fs_err", fs_err, 0);
        chk("R1 selects", {oc_lock, stop_pins_pair, cpu2_debug}, 0);

        // R2 no latch while power-good low; R6 mode ignored before latch
        fs_strap = 3'b010; trust_strap = 1'b1; mgmt_mode = 1'b1;
        step(3);
        chk("R2 no latch while pg low", straps_valid, 0);
        chk("R6 mgmt ignored before latch", in_mgmt, 0);
        mgmt_mode = 1'b0;

        // Exhaustive sweep over all strap combinations
        for (int v = 0; v < 64; v++) begin
            int fsv, tr, pr, db, exp_fs;
            fsv = v & 7; tr = (v >> 3) & 1; pr = (v >> 4) & 1; db = (v >> 5) & 1;
            do_reset();
            fs_strap = 3'(fsv); trust_strap = tr[0]; pair5_strap = pr[0]; dbg_strap = db[0];
            pwr_good = 1'b1;
            step(1);
            exp_fs = (fsv == 7) ? 5 : fsv;
            chk("R2 straps_valid", straps_valid, 1);
            chk("R2 strap_phase", strap_phase, 0);
            chk("R9 fs_code after latch", fs_code, exp_fs);
            chk("R9 fs_err after latch", fs_err, (fsv == 7) ? 1 : 0);
            chk("R3 cpu_freq", cpu_freq, exp_freq(exp_fs));
            chk("R11 oc_lock", oc_lock, tr);
            chk("R11 stop_pins_pair", stop_pins_pair, pr);
            chk("R11 cpu2_debug", cpu2_debug, db);
            // change raw straps and cycle power-good
            fs_strap = ~fs_strap; trust_strap = ~trust_strap;
            pair5_strap = ~pair5_strap; dbg_strap = ~dbg_strap;
            pwr_good = 1'b0;
            step(1);
            chk("R5 powered_down set", powered_down, 1);
            pwr_good = 1'b1;
            step(1);
            chk("R5 powered_down clear", powered_down, 0);
            chk("R4 fs_code held", fs_code, exp_fs);
            chk("R4 straps held", {oc_lock, stop_pins_pair, cpu2_debug}, {tr[0], pr[0], db[0]});
        end

        // Serial loading, all codes
        do_reset();
        fs_strap = 3'b000; pwr_good = 1'b1;
        step(1);
        model_fs = 0; model_err = 0;
        mgmt_mode = 1'b1;
        step(1);
        chk("R6 in_mgmt set", in_mgmt, 1);
        for (int c = 7; c >= 0; c--) begin
            shift_bit(c[2]);
            shift_bit(c[1]);
            chk("R7 no change after two bits", fs_code, model_fs);
            shift_bit(c[0]);
            if (c == 7) model_err = 1;
            else begin model_fs = c; model_err = 0; end
            chk("R7 serial code applied", fs_code, model_fs);
            chk("R9 serial fs_err", fs_err, model_err);
            chk("R3 cpu_freq after load", cpu_freq, exp_freq(model_fs));
        end

        // R8 partial load discarded
        shift_bit(1'b1);
        shift_bit(1'b1);
        mgmt_mode = 1'b0;
        step(1);
        chk("R6 in_mgmt clear", in_mgmt, 0);
        chk("R8 partial ignored", fs_code, model_fs);
        mgmt_mode = 1'b1;
        step(1);
        shift_code(2);
        model_fs = 2;
        chk("R8 fresh load after partial", fs_code, 2);

        // R10 shift clocks outside management mode
        mgmt_mode = 1'b0;
        step(1);
        shift_code(4);
        chk("R10 no load outside mgmt", fs_code, model_fs);

        // Coincidence: third rise together with mgmt_mode falling
        mgmt_mode = 1'b1;
        step(1);
        shift_bit(1'b1);
        shift_bit(1'b1);
        ser_data = 1'b0; ser_clk = 1'b1; mgmt_mode = 1'b0;
        step(1);
        ser_clk = 1'b0;
        chk("R7 commit on exit edge", fs_code, 6);
        chk("R6 exit on same edge", in_mgmt, 0);
        step(1);

        finish_run();
    end

endmodule